// File: doc/BRIEF.md
# Silence-Delimited Serial Frame Receiver with CRC-16 Check

This block sits behind a serial character receiver. It takes received bytes one at a time and finds where each frame begins and ends by measuring line silence. A gap of at least seven half-character periods (3.5 character times) with no byte closes the frame. The block runs a reflected CRC-16 over every byte of the frame, including the two trailing check bytes, and takes a zero remainder as a good frame.

For each frame of acceptable length, the block presents one report. The report carries the station address (byte 0), the function code (byte 1), an exception flag, the payload length and a CRC-good flag. The payload bytes, which are everything between the function code and the check bytes, are written into an internal buffer. A consumer reads that buffer through a plain read port while the report is held.

The byte input uses a valid/ready handshake. `in_ready` is high whenever no report is waiting. While a report is pending, `in_ready` is low and any byte offered is not taken, so the buffer cannot change under the consumer. The report output also uses valid/ready. A report stays valid, with all its fields stable, until the cycle in which `rpt_ready` is high. A pulse on `half_tick` marks each half-character period derived from the baud rate.

Top module: `modrx_frame_rx`

## Requirements
- R1: After reset, `rpt_valid` is 0 and `in_ready` is 1.
- R2: A frame ends on the seventh `half_tick` pulse counted after its last accepted byte. `rpt_valid` rises on the clock edge that samples that pulse. After only six pulses, the frame is still open, and a byte accepted then continues the same frame.
- R3: The check is a reflected CRC-16 with seed 0xFFFF and constant 0xA001. It shifts right and XORs in the constant when the bit shifted out is 1. `rpt_crc_ok` is 1 exactly when this CRC, run over all bytes of the frame including the two trailing bytes (low byte sent first), leaves 0x0000. The CRC restarts at 0xFFFF for every frame.
- R4: `rpt_addr` equals the first byte of the frame and `rpt_func` equals the second.
- R5: `rpt_exc` equals bit 7 of the function code.
- R6: `rpt_len` equals the frame length minus 4. Buffer address k holds frame byte k+2, for k from 0 to `rpt_len`-1.
- R7: A frame of fewer than 4 bytes or more than 256 bytes gives no report. A 256-byte frame is reported with `rpt_len` = 252.
- R8: While `rpt_valid` is 1 and `rpt_ready` is 0, all report fields stay stable and `in_ready` is 0. A cycle with `rpt_ready` high clears `rpt_valid` on that edge.
- R9: A byte accepted in the same cycle as a `half_tick` pulse restarts the silence count, and that pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle pulse per half character time |
| in_valid | input | 1 | Received byte is offered |
| in_ready | output | 1 | Byte is taken when valid and ready are both high |
| in_data | input | 8 | Received byte |
| rpt_valid | output | 1 | Frame report is available |
| rpt_ready | input | 1 | Consumer takes the report |
| rpt_addr | output | 8 | Station address byte |
| rpt_func | output | 8 | Function code byte |
| rpt_exc | output | 1 | Exception response flag |
| rpt_len | output | 8 | Payload byte count |
| rpt_crc_ok | output | 1 | CRC remainder was zero |
| pay_raddr | input | 8 | Payload buffer read address |
| pay_rdata | output | 8 | Payload byte at `pay_raddr` (combinational) |

## Verification
The report is due one clock edge after the seventh `half_tick` pulse that follows the last byte, so the bench checks `rpt_valid` at the falling edge right after six pulses, and again right after the seventh. The buffer read is combinational, so each payload byte is sampled a short delay after the address changes, with no clock edge in between. Handshake effects (`in_ready` falling with the report, `rpt_valid` clearing after `rpt_ready`) are checked at the falling edge that follows the causing rising edge. The bench compares the results against CRC values and field values it computes itself over random and directed frames.

// File: rtl/modrx_pkg.sv
package modrx_pkg;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_REFL_POLY = 16'hA001;

  // One byte through the reflected CRC-16, eight right shifts
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      if (r[0]) r = (r >> 1) ^ CRC_REFL_POLY;
      else      r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/modrx_gap_timer.sv
module modrx_gap_timer #(
  parameter int GAP_HALVES = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic byte_i,
  output logic gap_hit_o
);
  localparam int CW = $clog2(GAP_HALVES + 1);
  localparam logic [CW-1:0] SAT = CW'(GAP_HALVES);
  localparam logic [CW-1:0] LAST = CW'(GAP_HALVES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= SAT;
    else if (byte_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign gap_hit_o = tick_i && !byte_i && (cnt_q == LAST);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_i |=> cnt_q == '0);
  p_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == SAT |=> (cnt_q == SAT) || (cnt_q == '0));
endmodule

// File: rtl/modrx_crc16.sv
module modrx_crc16
  import modrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  input  logic        clr_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_SEED;
    else if (en_i)  crc_q <= crc16_byte(crc_q, data_i);
    else if (clr_i) crc_q <= CRC_SEED;
  end

  assign crc_o = crc_q;

  p_seed_after_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !en_i |=> crc_q == CRC_SEED);
endmodule

// File: rtl/modrx_paybuf.sv
module modrx_paybuf #(
  parameter int DEPTH = 254,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem[waddr_i] <= wdata_i;
  end

  always_comb begin
    rdata_o = 8'h00;
    if (int'(raddr_i) < DEPTH) rdata_o = mem[raddr_i];
  end
endmodule

// File: rtl/modrx_frame_rx.sv
module modrx_frame_rx
  import modrx_pkg::*;
#(
  parameter int MAX_FRAME  = 256,
  parameter int MIN_FRAME  = 4,
  parameter int GAP_HALVES = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       rpt_valid,
  input  logic       rpt_ready,
  output logic [7:0] rpt_addr,
  output logic [7:0] rpt_func,
  output logic       rpt_exc,
  output logic [7:0] rpt_len,
  output logic       rpt_crc_ok,
  input  logic [7:0] pay_raddr,
  output logic [7:0] pay_rdata
);
  localparam int CNT_W = $clog2(MAX_FRAME + 2);
  localparam int PAY_DEPTH = MAX_FRAME - 2;
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_FRAME + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_FRAME);

  logic             in_fire, gap_hit, frame_done, len_ok, buf_we;
  logic             in_frame_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       addr_q, func_q;
  logic [15:0]      crc;
  logic [CNT_W-1:0] widx;

  assign in_ready   = !rpt_valid;
  assign in_fire    = in_valid && in_ready;
  assign frame_done = in_frame_q && gap_hit;
  assign len_ok     = (cnt_q >= CNT_MIN) && (cnt_q <= CNT_MAX);

  modrx_gap_timer #(.GAP_HALVES(GAP_HALVES)) u_gap (
    .clk(clk), .rst_n(rst_n), .tick_i(half_tick), .byte_i(in_fire),
    .gap_hit_o(gap_hit));

  modrx_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .en_i(in_fire), .data_i(in_data),
    .clr_i(frame_done), .crc_o(crc));

  // Payload starts at frame byte 2; check bytes land too but are not counted
  assign widx   = cnt_q - CNT_W'(2);
  assign buf_we = in_fire && in_frame_q && (cnt_q >= CNT_W'(2)) && (cnt_q < CNT_MAX);

  modrx_paybuf #(.DEPTH(PAY_DEPTH), .AW(8)) u_buf (
    .clk(clk), .we_i(buf_we), .waddr_i(widx[7:0]), .wdata_i(in_data),
    .raddr_i(pay_raddr), .rdata_o(pay_rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      addr_q     <= '0;
      func_q     <= '0;
    end else if (in_fire) begin
      in_frame_q <= 1'b1;
      if (!in_frame_q) begin
        cnt_q  <= CNT_W'(1);
        addr_q <= in_data;
      end else begin
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(1)) func_q <= in_data;
      end
    end else if (frame_done) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_valid  <= 1'b0;
      rpt_addr   <= '0;
      rpt_func   <= '0;
      rpt_exc    <= 1'b0;
      rpt_len    <= '0;
      rpt_crc_ok <= 1'b0;
    end else if (frame_done && len_ok) begin
      rpt_valid  <= 1'b1;
      rpt_addr   <= addr_q;
      rpt_func   <= func_q;
      rpt_exc    <= func_q[7];
      rpt_len    <= 8'(cnt_q - CNT_MIN);
      rpt_crc_ok <= (crc == 16'h0000);
    end else if (rpt_valid && rpt_ready) begin
      rpt_valid <= 1'b0;
    end
  end

  p_end_is_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !in_fire);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && !rpt_ready |=> rpt_valid && $stable(rpt_addr) && $stable(rpt_func)
      && $stable(rpt_len) && $stable(rpt_crc_ok) && $stable(rpt_exc));
  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> int'(rpt_len) <= MAX_FRAME - MIN_FRAME);
  p_no_write_while_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> !buf_we);
endmodule

// File: tb/tb_modrx_frame_rx.sv
module tb_modrx_frame_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 1'b0, in_valid = 1'b0, rpt_ready = 1'b0;
  logic [7:0] in_data = 8'h00, pay_raddr = 8'h00;
  logic in_ready, rpt_valid, rpt_exc, rpt_crc_ok;
  logic [7:0] rpt_addr, rpt_func, rpt_len, pay_rdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0] fr [0:299];
  int fn;

  always #10 clk = ~clk;

  modrx_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .rpt_valid(rpt_valid),
    .rpt_ready(rpt_ready), .rpt_addr(rpt_addr), .rpt_func(rpt_func),
    .rpt_exc(rpt_exc), .rpt_len(rpt_len), .rpt_crc_ok(rpt_crc_ok),
    .pay_raddr(pay_raddr), .pay_rdata(pay_rdata));

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, fr[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) half_tick = 1'b1;
    @(negedge clk) half_tick = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input bit with_tick);
    @(negedge clk) begin in_valid = 1'b1; in_data = b; half_tick = with_tick; end
    @(negedge clk) begin in_valid = 1'b0; half_tick = 1'b0; end
  endtask

  // Builds frame: addr, func, payload, then CRC low, high
  task automatic build(input int plen, input bit exc);
    fr[0] = 8'($urandom);
    fr[1] = {exc, 7'($urandom)};
    for (int i = 0; i < plen; i++) fr[2 + i] = 8'($urandom);
    fn = plen + 2;
    begin
      logic [15:0] c = ref_crc(fn);
      fr[fn] = c[7:0];
      fr[fn + 1] = c[15:8];
    end
    fn = fn + 2;
  endtask

  task automatic send(input int n, input bit last_tick);
    for (int i = 0; i < n; i++) begin
      put_byte(fr[i], (i == n - 1) && last_tick);
      if (i < n - 1) begin pulse_tick(); pulse_tick(); end
    end
  endtask

  task automatic close_and_check(input bit expect_rpt, input bit crc_good, input string tag);
    for (int i = 0; i < 6; i++) pulse_tick();
    chk(rpt_valid == 1'b0, "R2 open after 6 ticks", rpt_valid, 0);
    pulse_tick();
    chk(rpt_valid == expect_rpt, tag, rpt_valid, expect_rpt);
    if (expect_rpt && rpt_valid) begin
      chk(rpt_addr == fr[0], "R4 addr", rpt_addr, fr[0]);
      chk(rpt_func == fr[1], "R4 func", rpt_func, fr[1]);
      chk(rpt_exc == fr[1][7], "R5 exc", rpt_exc, fr[1][7]);
      chk(int'(rpt_len) == fn - 4, "R6 len", rpt_len, fn - 4);
      chk(rpt_crc_ok == crc_good, "R3 crc_ok", rpt_crc_ok, crc_good);
      for (int k = 0; k < fn - 4; k++) begin
        pay_raddr = 8'(k);
        #1;
        chk(pay_rdata == fr[k + 2], "R6 payload", pay_rdata, fr[k + 2]);
      end
      repeat (3) @(negedge clk);
      chk(rpt_valid && !in_ready && rpt_addr == fr[0], "R8 held", in_ready, 0);
      rpt_ready = 1'b1;
      @(negedge clk) rpt_ready = 1'b0;
      chk(rpt_valid == 1'b0 && in_ready, "R8 released", rpt_valid, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(rpt_valid == 1'b0 && in_ready == 1'b1, "R1 reset", rpt_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rpt_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", in_ready, 1);

    // Directed: known good frame 01 08 00 00 13 88 ED 5D
    fr[0] = 8'h01; fr[1] = 8'h08; fr[2] = 8'h00; fr[3] = 8'h00;
    fr[4] = 8'h13; fr[5] = 8'h88; fr[6] = 8'hED; fr[7] = 8'h5D; fn = 8;
    chk(ref_crc(8) == 16'h0000, "R3 known vector", ref_crc(8), 0);
    send(fn, 1'b0);
    close_and_check(1'b1, 1'b1, "R3 known frame");

    // Directed: exception response 01 88 03 06 01
    fr[0] = 8'h01; fr[1] = 8'h88; fr[2] = 8'h03; fr[3] = 8'h06; fr[4] = 8'h01; fn = 5;
    send(fn, 1'b0);
    close_and_check(1'b1, 1'b1, "R5 exception frame");

    // Random frames, some corrupted
    for (int t = 0; t < 12; t++) begin
      bit bad;
      build(int'($urandom_range(0, 20)), 1'($urandom));
      bad = (t % 3 == 2);
      if (bad) fr[1 + $urandom_range(0, fn - 2)] ^= 8'h10;
      send(fn, 1'b0);
      close_and_check(1'b1, !bad, "R3 random frame");
    end

    // Too short: 3 bytes
    build(0, 1'b0); fn = 3;
    send(fn, 1'b0);
    close_and_check(1'b0, 1'b0, "R7 short frame dropped");

    // Maximum length 256 bytes
    build(252, 1'b0);
    send(fn, 1'b0);
    close_and_check(1'b1, 1'b1, "R7 max frame kept");

    // Too long: 257 bytes
    build(253, 1'b0);
    send(fn, 1'b0);
    close_and_check(1'b0, 1'b0, "R7 long frame dropped");

    // Byte coinciding with a tick: the tick is not counted (R9)
    build(3, 1'b0);
    send(fn, 1'b1);
    close_and_check(1'b1, 1'b1, "R9 coincident tick");

    // Six-tick gap does not split a frame (R2)
    build(4, 1'b1);
    for (int i = 0; i < fn; i++) begin
      put_byte(fr[i], 1'b0);
      if (i == 3) begin
        for (int k = 0; k < 6; k++) pulse_tick();
      end else if (i < fn - 1) begin
        pulse_tick();
      end
    end
    close_and_check(1'b1, 1'b1, "R2 six-tick gap joins");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule